// File: doc/BRIEF.md
# Slow Voltage-Ramp Exit Controller

This block runs the exit sequence out of the deep idle states (C4/C5). It shows the processor voltage regulator how fast to ramp back up. Fast voltage ramps that repeat at a regular rate, for example on every system timer tick, can cause audible noise. When the feature is enabled, the controller treats two interrupt lines, the usual timer-tick sources, as slow wake events. It asks for a gentle ramp on those lines and inserts an extra, configurable wait before it starts the normal ramp timer. Every other wake source takes the quick path.

The controller drives two regulator control lines. The first is an active-low deeper-stop line, which is released (driven high) on any exit. The second is a sleep-voltage select line: it stays high for a gentle ramp and drops low for a normal one. The controller also issues a one-cycle pulse that starts the downstream ramp timer. A fast event that arrives during the extra wait cuts the wait short at once. When fast and slow events arrive in the same cycle, the fast path is taken. Outside an exit, the regulator lines rest at their sleep values and wake inputs have no effect. The sequence is torn down as soon as the deep-state flag drops.

Top module: `slow_exit_ctrl`

## Requirements
- R1: After reset is asserted, the outputs are deep_stop_no=0, sleep_vsel_o=1 and ramp_start_o=0.
- R2: While deep_i is low, the outputs stay at deep_stop_no=0, sleep_vsel_o=1 and ramp_start_o=0, whatever is applied to irq_i, fast_brk_i and slow_en_i.
- R3: With slow_en_i=1, consider an idle controller with deep_i=1 whose only wake events are irq_i[0] and/or irq_i[8]. On the next cycle it shows deep_stop_no=1, sleep_vsel_o=1 and ramp_start_o=0 (slow wait).
- R4: With slow_en_i=0, irq_i[0] and irq_i[8] behave as fast events, with the same response as R5.
- R5: A fast event while idle with deep_i=1 gives deep_stop_no=1, sleep_vsel_o=0 and ramp_start_o=1 on the next cycle. A fast event is fast_brk_i, or any irq_i bit other than 0 and 8, or bit 0 or 8 when slow_en_i=0.
- R6: When a fast event and a slow event arrive in the same cycle, the fast response of R5 is taken.
- R7: The slow wait holds deep_stop_no=1 and sleep_vsel_o=1 for slow_dly_i+1 cycles, with slow_dly_i sampled when the wait begins. On the following cycle sleep_vsel_o goes low and ramp_start_o pulses.
- R8: A fast event during the slow wait gives sleep_vsel_o=0 and ramp_start_o=1 on the next cycle, however much of the wait remains.
- R9: ramp_start_o is high for exactly one cycle per exit. After the pulse, deep_stop_no=1 and sleep_vsel_o=0 hold, and further wake events are ignored, until deep_i drops.
- R10: When deep_i is low at a clock edge, in any phase of the exit, the next cycle shows deep_stop_no=0, sleep_vsel_o=1 and ramp_start_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_en_i | input | 1 | Enables slow classification of interrupt lines 0 and 8 |
| deep_i | input | 1 | High while the platform is in, or leaving, C4/C5 |
| irq_i | input | 24 | Interrupt wake events, one bit per line |
| fast_brk_i | input | 1 | Any other wake source, always fast |
| slow_dly_i | input | 8 | Extra slow-wait length, minus one cycle |
| deep_stop_no | output | 1 | Deeper-stop regulator control, active low |
| sleep_vsel_o | output | 1 | Sleep-voltage select, high requests a gentle ramp |
| ramp_start_o | output | 1 | One-cycle start pulse for the ramp timer |

## Verification
Four kinds of check run on every cycle. The assertions confirm that the ramp pulse never lasts two cycles and always shows the normal-ramp regulator values. They confirm that a dropped deep flag returns the sleep values, that the select line falls only together with the ramp pulse, and that slow-only, fast and mixed wake events lead to the right next phase. The exact length of the slow wait cannot be shown that way, because it depends on a configured value. The same holds for a mid-wait fast event that abandons the remaining count and for the one-pulse-per-exit rule; directed bench scenarios and a cycle-by-cycle reference under random wake traffic show these.

// File: rtl/slow_exit_pkg.sv
package slow_exit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SLOW_WAIT = 2'd1,
    ST_RAMP      = 2'd2,
    ST_DONE      = 2'd3
  } exit_st_e;

  typedef struct packed {
    logic stop_n;
    logic vsel;
    logic ramp;
  } vr_ctl_t;

  function automatic vr_ctl_t vr_decode(exit_st_e st);
    case (st)
      ST_SLOW_WAIT: return '{stop_n: 1'b1, vsel: 1'b1, ramp: 1'b0};
      ST_RAMP:      return '{stop_n: 1'b1, vsel: 1'b0, ramp: 1'b1};
      ST_DONE:      return '{stop_n: 1'b1, vsel: 1'b0, ramp: 1'b0};
      default:      return '{stop_n: 1'b0, vsel: 1'b1, ramp: 1'b0};
    endcase
  endfunction
endpackage

// File: rtl/sx_break_class.sv
module sx_break_class #(
  parameter int N_IRQ  = 24,
  parameter int SLOW_A = 0,
  parameter int SLOW_B = 8
) (
  input  logic             en_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             fast_brk_i,
  output logic             slow_o,
  output logic             fast_o
);
  logic [N_IRQ-1:0] slow_hit, fast_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    localparam bit IS_SLOW = (i == SLOW_A) || (i == SLOW_B);
    if (IS_SLOW) begin : g_slow
      assign slow_hit[i] = irq_i[i] & en_i;
      assign fast_hit[i] = irq_i[i] & ~en_i;
    end else begin : g_fast
      assign slow_hit[i] = 1'b0;
      assign fast_hit[i] = irq_i[i];
    end
  end

  assign slow_o = |slow_hit;
  assign fast_o = fast_brk_i | (|fast_hit);
endmodule

// File: rtl/sx_delay_cnt.sv
module sx_delay_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/slow_exit_ctrl.sv
module slow_exit_ctrl
  import slow_exit_pkg::*;
#(
  parameter int N_IRQ  = 24,
  parameter int SLOW_A = 0,
  parameter int SLOW_B = 8,
  parameter int DLY_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_en_i,
  input  logic             deep_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             fast_brk_i,
  input  logic [DLY_W-1:0] slow_dly_i,
  output logic             deep_stop_no,
  output logic             sleep_vsel_o,
  output logic             ramp_start_o
);
  exit_st_e st_q, st_d;
  logic     brk_slow, brk_fast;
  logic     cnt_load, cnt_dec, cnt_zero;
  vr_ctl_t  ctl;

  sx_break_class #(
    .N_IRQ (N_IRQ),
    .SLOW_A(SLOW_A),
    .SLOW_B(SLOW_B)
  ) u_class (
    .en_i      (slow_en_i),
    .irq_i     (irq_i),
    .fast_brk_i(fast_brk_i),
    .slow_o    (brk_slow),
    .fast_o    (brk_fast)
  );

  sx_delay_cnt #(.W(DLY_W)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cnt_load),
    .val_i (slow_dly_i),
    .dec_i (cnt_dec),
    .zero_o(cnt_zero)
  );

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (!deep_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          // fast wins over slow
          if (brk_fast) st_d = ST_RAMP;
          else if (brk_slow) begin
            st_d     = ST_SLOW_WAIT;
            cnt_load = 1'b1;
          end
        end
        ST_SLOW_WAIT: begin
          if (brk_fast || cnt_zero) st_d = ST_RAMP;
          else cnt_dec = 1'b1;
        end
        ST_RAMP: st_d = ST_DONE;
        default: st_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign ctl          = vr_decode(st_q);
  assign deep_stop_no = ctl.stop_n;
  assign sleep_vsel_o = ctl.vsel;
  assign ramp_start_o = ctl.ramp;
endmodule

// File: rtl/slow_exit_chk.sv
module slow_exit_chk
  import slow_exit_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     deep_i,
  input exit_st_e st_i,
  input logic     fast_i,
  input logic     slow_i,
  input logic     deep_stop_no,
  input logic     sleep_vsel_o,
  input logic     ramp_start_o
);
  // R9
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_start_o |=> !ramp_start_o);

  // R5
  pulse_levels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_start_o |-> (deep_stop_no && !sleep_vsel_o));

  // R10
  deep_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deep_i |=> (!deep_stop_no && sleep_vsel_o && !ramp_start_o));

  // R5
  vsel_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_vsel_o) |-> ramp_start_o);

  // R3
  slow_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && deep_i && slow_i && !fast_i)
      |=> (deep_stop_no && sleep_vsel_o && !ramp_start_o));

  // R6
  fast_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && deep_i && fast_i) |=> ramp_start_o);

  // R8
  fast_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SLOW_WAIT && deep_i && fast_i) |=> ramp_start_o);
endmodule

bind slow_exit_ctrl slow_exit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .deep_i      (deep_i),
  .st_i        (st_q),
  .fast_i      (brk_fast),
  .slow_i      (brk_slow),
  .deep_stop_no(deep_stop_no),
  .sleep_vsel_o(sleep_vsel_o),
  .ramp_start_o(ramp_start_o)
);

// File: tb/tb_slow_exit_ctrl.sv
module tb_slow_exit_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 24;
  localparam int DLY_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             slow_en_i = 1'b0;
  logic             deep_i = 1'b0;
  logic [N_IRQ-1:0] irq_i = '0;
  logic             fast_brk_i = 1'b0;
  logic [DLY_W-1:0] slow_dly_i = '0;
  logic             deep_stop_no, sleep_vsel_o, ramp_start_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  slow_exit_ctrl dut (
    .clk_i, .rst_ni, .slow_en_i, .deep_i, .irq_i, .fast_brk_i, .slow_dly_i,
    .deep_stop_no, .sleep_vsel_o, .ramp_start_o
  );

  // expectation helpers from the requirements
  function automatic bit is_slow(logic en, logic [N_IRQ-1:0] irq);
    return en && (irq[0] || irq[8]);
  endfunction

  function automatic bit is_fast(logic en, logic [N_IRQ-1:0] irq, logic fb);
    logic [N_IRQ-1:0] m;
    m = en ? (N_IRQ'(1) | (N_IRQ'(1) << 8)) : '0;
    return fb || ((irq & ~m) != '0);
  endfunction

  // phase: 0 idle, 1 slow wait, 2 pulse, 3 hold
  function automatic logic [2:0] exp_out(int ph);
    case (ph)
      1: return 3'b110;
      2: return 3'b101;
      3: return 3'b100;
      default: return 3'b010;
    endcase
  endfunction

  function automatic string ph_req(int ph);
    case (ph)
      1: return "R7";
      2: return "R5";
      3: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] outs();
    return {deep_stop_no, sleep_vsel_o, ramp_start_o};
  endfunction

  // reference sequence tracker
  int m_ph = 0;
  int m_cnt = 0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph <= 0; m_cnt <= 0;
    end else if (!deep_i) begin
      m_ph <= 0;
    end else begin
      case (m_ph)
        0: if (is_fast(slow_en_i, irq_i, fast_brk_i)) m_ph <= 2;
           else if (is_slow(slow_en_i, irq_i)) begin m_ph <= 1; m_cnt <= int'(slow_dly_i); end
        1: if (is_fast(slow_en_i, irq_i, fast_brk_i) || m_cnt == 0) m_ph <= 2;
           else m_cnt <= m_cnt - 1;
        default: m_ph <= 3;
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done)
      check(outs() == exp_out(m_ph), ph_req(m_ph), 32'(outs()), 32'(exp_out(m_ph)));
  end

  task automatic tick(); @(negedge clk_i); endtask

  task automatic go_idle();
    deep_i = 1'b0; irq_i = '0; fast_brk_i = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    int cnt;
    seed = $urandom(32'h1357);
    tick(); tick();
    // R1
    check(outs() == 3'b010, "R1", 32'(outs()), 32'h2);
    rst_ni = 1'b1;
    tick();

    // R2: wake events without deep flag
    deep_i = 1'b0; irq_i = '1; fast_brk_i = 1'b1; slow_en_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(outs() == 3'b010, "R2", 32'(outs()), 32'h2);
    end
    go_idle();

    // R5 fast via irq 5, then R9 hold, then R10
    deep_i = 1'b1; irq_i = N_IRQ'(1) << 5;
    tick();
    check(outs() == 3'b101, "R5", 32'(outs()), 32'h5);
    irq_i = '1; fast_brk_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(outs() == 3'b100, "R9", 32'(outs()), 32'h4);
    end
    deep_i = 1'b0; irq_i = '0; fast_brk_i = 1'b0;
    tick();
    check(outs() == 3'b010, "R10", 32'(outs()), 32'h2);

    // R4 disabled: line 8 is fast
    slow_en_i = 1'b0; deep_i = 1'b1; irq_i = N_IRQ'(1) << 8;
    tick();
    check(outs() == 3'b101, "R4", 32'(outs()), 32'h5);
    go_idle();

    // R3 + R7: slow exit with delay 3 -> 4 wait cycles
    slow_en_i = 1'b1; deep_i = 1'b1; irq_i = N_IRQ'(1); slow_dly_i = 8'd3;
    tick();
    check(outs() == 3'b110, "R3", 32'(outs()), 32'h6);
    irq_i = '0; slow_dly_i = 8'd50;
    cnt = 1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (outs() != 3'b110) break;
      cnt++;
    end
    check(cnt == 4, "R7", 32'(cnt), 32'd4);
    check(outs() == 3'b101, "R7", 32'(outs()), 32'h5);
    tick();
    check(outs() == 3'b100, "R9", 32'(outs()), 32'h4);
    go_idle();

    // R7 zero delay -> single wait cycle
    deep_i = 1'b1; irq_i = N_IRQ'(1) << 8; slow_dly_i = 8'd0;
    tick();
    irq_i = '0;
    check(outs() == 3'b110, "R7", 32'(outs()), 32'h6);
    tick();
    check(outs() == 3'b101, "R7", 32'(outs()), 32'h5);
    go_idle();

    // R8: fast event aborts long wait
    deep_i = 1'b1; irq_i = N_IRQ'(1) << 8; slow_dly_i = 8'd100;
    tick();
    irq_i = '0;
    tick(); tick();
    check(outs() == 3'b110, "R8", 32'(outs()), 32'h6);
    fast_brk_i = 1'b1;
    tick();
    fast_brk_i = 1'b0;
    check(outs() == 3'b101, "R8", 32'(outs()), 32'h5);
    go_idle();

    // R6: slow and fast together
    deep_i = 1'b1; irq_i = N_IRQ'(1) | (N_IRQ'(1) << 9);
    tick();
    check(outs() == 3'b101, "R6", 32'(outs()), 32'h5);
    go_idle();

    // R10 during slow wait
    deep_i = 1'b1; irq_i = N_IRQ'(1); slow_dly_i = 8'd20;
    tick();
    irq_i = '0; deep_i = 1'b0;
    tick();
    check(outs() == 3'b010, "R10", 32'(outs()), 32'h2);

    // random traffic against the reference tracker
    for (int i = 0; i < 3000; i++) begin
      if (!deep_i) begin
        slow_en_i = 1'($urandom % 2);
        deep_i = ($urandom % 4) != 0;
      end else if ($urandom % 25 == 0) deep_i = 1'b0;
      case ($urandom % 6)
        0: irq_i = N_IRQ'(1) << ($urandom % N_IRQ);
        1: irq_i = ($urandom % 2) ? N_IRQ'(1) : (N_IRQ'(1) << 8);
        2: irq_i = (N_IRQ'(1) << ($urandom % N_IRQ)) | N_IRQ'(1);
        default: irq_i = '0;
      endcase
      fast_brk_i = ($urandom % 12) == 0;
      slow_dly_i = DLY_W'($urandom % 8);
      tick();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule